// File: doc/BRIEF.md
# RF Front-End Control Bus Slave Decoder

This block is the serial slave for a two-wire RF front-end control bus. It oversamples the bus clock and data line with a faster system clock and detects the start condition. It then decodes four kinds of command: a plain register write, a register read, an extended write of one to four consecutive registers, and a short write to register 0 that carries seven payload bits and no address. Every frame carries an odd-parity bit. A frame that fails parity is dropped without any side effect.

On the core side the block drives one-cycle write strobes with address and data into an external register bank. For reads it issues a one-cycle read strobe with an address and takes the returned byte from the bank. It then shifts that byte out on the data line, adds parity, and ends the transfer with a bus park cycle. The 4-bit slave identifier comes in from the register bank. Identifier 0000 is a broadcast address that only write commands can use, and only for a small window of high registers.

Top module: `rffe_slave`

## Requirements
- R1: After reset `wr_en`, `rd_en` and `sdata_oe` are all low.
- R2: A start condition is a rise and then a fall of the data line while the bus clock stays low. Bits are sampled on bus clock falling edges. A new start condition in the middle of a frame abandons that frame and begins a new command frame.
- R3: A register write has a 13-bit command frame and then a 9-bit data frame. The command frame is the slave ID (4 bits, MSB first), bits 010, a 5-bit address and parity. The data frame is 8 data bits, MSB first, and parity. When the data parity is good the block gives one `wr_en` pulse with that address and data.
- R4: A short write has a 13-bit frame: the slave ID, a 1 bit, 7 payload bits and parity. It writes address 0 with the payload zero-extended to 8 bits.
- R5: An extended write has a command frame made of the slave ID, bits 0000, a 4-bit count and parity. The count gives the number of bytes minus one. An address frame of 8 bits plus parity follows, then the data bytes, each of 8 bits plus parity. Each byte is written once its parity checks, and the address steps up by one per byte. A count above 3 makes the block ignore the whole sequence.
- R6: A register read has a command frame made of the slave ID, bits 011, a 5-bit address and parity. The block pulses `rd_en` with `rd_addr`. The master then parks the bus for one clock, and the block captures `rd_data` on that clock's rising edge. On the next nine rising edges it drives D7 down to D0 and then an odd-parity bit. After that it drives low for the high half of the park clock and releases the line on that clock's falling edge. Driven data changes only while the bus clock is high.
- R7: A frame whose ones count, parity included, is even is ignored. In an extended write, a byte with bad parity ends the sequence. Bytes already checked stay written.
- R8: A frame whose slave ID is neither `usid` nor 0000 causes no strobe and no drive.
- R9: Slave ID 0000 is accepted for writes only, and only to registers 27 to 31. Such writes to other addresses and broadcast reads are ignored.
- R10: `wr_en` and `rd_en` are one-cycle pulses. They are never high together, and neither is high while the block drives the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Bus clock from the master |
| sdata_in | input | 1 | Data line as seen at the pin |
| sdata_out | output | 1 | Data value driven during reads and park |
| sdata_oe | output | 1 | Data line output enable |
| usid | input | 4 | Slave identifier from the register bank |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| rd_en | output | 1 | One-cycle register read strobe |
| rd_addr | output | 8 | Read address, held until the next read |
| rd_data | input | 8 | Read data from the bank, valid from the cycle after `rd_en` |

## Verification
The checker watches the strobe shape on every cycle. Writes and reads must be single pulses, never coincide, and never overlap the block driving the line. It also checks that driven data only changes while the bus clock is high and that each release of the line follows a driven low, which is the park cycle. Frame decoding can only be shown by the bench's scenarios. These cover the field positions of each command, parity rejection, identifier and broadcast filtering, extended write auto-increment and its count limit, abort on a bad byte, and resynchronisation on a new start condition.

// File: rtl/rffe_slave.sv
module rffe_slave #(
  parameter int BCAST_LO  = 27,
  parameter int BCAST_HI  = 31,
  parameter int MAX_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       sdata_in,
  output logic       sdata_out,
  output logic       sdata_oe,
  input  logic [3:0] usid,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_en,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  localparam logic [7:0] BLO    = 8'(BCAST_LO);
  localparam logic [7:0] BHI    = 8'(BCAST_HI);
  localparam logic [3:0] BC_MAX = 4'(MAX_BYTES - 1);

  typedef enum logic [2:0] {IDLE, CMD, WDAT, EADR, EDAT, RDOUT, PARK} st_t;

  logic [2:0]  ck_q, dt_q;
  logic        arm, par, bc;
  st_t         st;
  logic [3:0]  cnt, left;
  logic [11:0] sh;
  logic [7:0]  addr;
  logic [8:0]  rsh;

  wire sck     = ck_q[1];
  wire sd      = dt_q[1];
  wire sck_r   = sck & ~ck_q[2];
  wire sck_f   = ~sck & ck_q[2];
  wire sd_r    = sd & ~dt_q[2];
  wire sd_f    = ~sd & dt_q[2];
  wire ssc_det = arm & sd_f & ~sck;
  wire pok     = par ^ sd;
  wire id_hit  = sh[11:8] == usid;
  wire bc_hit  = sh[11:8] == 4'd0;
  wire [7:0] a5 = {3'b000, sh[4:0]};

  function automatic logic in_bc(input logic [7:0] a);
    return (a >= BLO) && (a <= BHI);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0; dt_q <= '0; arm <= 1'b0;
      st <= IDLE; cnt <= '0; left <= '0; sh <= '0; par <= 1'b0;
      bc <= 1'b0; addr <= '0; rsh <= '0;
      sdata_out <= 1'b0; sdata_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      rd_en <= 1'b0; rd_addr <= '0;
    end else begin
      ck_q  <= {ck_q[1:0], sclk};
      dt_q  <= {dt_q[1:0], sdata_in};
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (sck || ssc_det) arm <= 1'b0;
      else if (sd_r)      arm <= 1'b1;

      if (ssc_det) begin
        st <= CMD; cnt <= '0; par <= 1'b0;
        sdata_oe <= 1'b0; sdata_out <= 1'b0;
      end else begin
        case (st)
          CMD: if (sck_f) begin
            sh  <= {sh[10:0], sd};
            par <= par ^ sd;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd12) begin
              cnt <= '0; par <= 1'b0; st <= IDLE;
              if (pok) begin
                if (sh[7]) begin
                  if (id_hit) begin
                    wr_en <= 1'b1; wr_addr <= '0; wr_data <= {1'b0, sh[6:0]};
                  end
                end else if (sh[6:5] == 2'b10) begin
                  addr <= a5;
                  if (id_hit || (bc_hit && in_bc(a5))) st <= WDAT;
                end else if (sh[6:5] == 2'b11) begin
                  if (id_hit) begin
                    rd_en <= 1'b1; rd_addr <= a5; st <= RDOUT;
                  end
                end else if (sh[6:4] == 3'b000) begin
                  if ((id_hit || bc_hit) && sh[3:0] <= BC_MAX) begin
                    left <= sh[3:0]; bc <= ~id_hit; st <= EADR;
                  end
                end
              end
            end
          end
          WDAT, EADR, EDAT: if (sck_f) begin
            sh  <= {sh[10:0], sd};
            par <= par ^ sd;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd8) begin
              cnt <= '0; par <= 1'b0;
              if (!pok) st <= IDLE;
              else if (st == WDAT) begin
                wr_en <= 1'b1; wr_addr <= addr; wr_data <= sh[7:0]; st <= IDLE;
              end else if (st == EADR) begin
                addr <= sh[7:0]; st <= EDAT;
              end else begin
                if (!bc || in_bc(addr)) begin
                  wr_en <= 1'b1; wr_addr <= addr; wr_data <= sh[7:0];
                end
                addr <= addr + 8'd1;
                if (left == 4'd0) st <= IDLE;
                else left <= left - 4'd1;
              end
            end
          end
          RDOUT: if (sck_r) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd0) rsh <= {rd_data, ~^rd_data};
            else if (cnt <= 4'd9) begin
              sdata_oe <= 1'b1; sdata_out <= rsh[8]; rsh <= {rsh[7:0], 1'b0};
            end else begin
              sdata_out <= 1'b0; cnt <= '0; st <= PARK;
            end
          end
          PARK: if (sck_f) begin
            sdata_oe <= 1'b0; st <= IDLE;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rffe_slave_chk.sv
module rffe_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdata_out,
  input logic sdata_oe,
  input logic wr_en,
  input logic rd_en,
  input logic ssc
);
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R10
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> !(wr_en && rd_en) && !sdata_oe); // R10
  AST_DRIVE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && $past(sdata_oe) && !$stable(sdata_out)) |-> sclk); // R6
  AST_PARK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> (!$past(sdata_out) && !sclk) || $past(ssc)); // R6
endmodule

bind rffe_slave rffe_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_out(sdata_out),
  .sdata_oe(sdata_oe), .wr_en(wr_en), .rd_en(rd_en), .ssc(ssc_det)
);

// File: tb/sim_rffe_slave.sv
module sim_rffe_slave;
  localparam int H = 80;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, m_dat = 1'b0;
  logic sdata_out, sdata_oe, wr_en, rd_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [3:0] usid = 4'h7;
  wire line = sdata_oe ? sdata_out : m_dat;
  int n_chk = 0, n_err = 0, wcnt = 0, rcnt = 0;
  logic oe_seen = 1'b0, done = 1'b0;
  logic [7:0] wa [64];
  logic [7:0] wd [64];

  always #2 clk = ~clk;

  function automatic logic [7:0] bank(input logic [7:0] a);
    return a * 8'd13 + 8'h5A;
  endfunction
  assign rd_data = bank(rd_addr);

  rffe_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_in(line),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .usid(usid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (wr_en) begin wa[wcnt % 64] = wr_addr; wd[wcnt % 64] = wr_data; wcnt++; end
    if (rd_en) rcnt++;
    if (sdata_oe) oe_seen = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    sclk = 1'b1; m_dat = b; #H; sclk = 1'b0; #H;
  endtask
  task automatic ssc();
    m_dat = 1'b0; #H; m_dat = 1'b1; #H; m_dat = 1'b0; #H;
  endtask
  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask
  task automatic frame(input logic [15:0] v, input int n, input logic flip);
    send(v, n); clk_bit((~^v) ^ flip);
  endtask

  task automatic do_write(input logic [3:0] sa, input logic [4:0] a, input logic [7:0] d, input logic [1:0] bad);
    ssc(); frame({4'h0, sa, 3'b010, a}, 12, bad == 2'd1);
    frame({8'h0, d}, 8, bad == 2'd2); clk_bit(1'b0);
  endtask
  task automatic do_short(input logic [3:0] sa, input logic [6:0] d, input logic [1:0] bad);
    ssc(); frame({4'h0, sa, 1'b1, d}, 12, bad == 2'd1); clk_bit(1'b0);
  endtask
  task automatic do_read(input logic [3:0] sa, input logic [4:0] a, output logic [8:0] got, output logic park_ok);
    ssc(); frame({4'h0, sa, 3'b011, a}, 12, 1'b0); clk_bit(1'b0);
    for (int i = 8; i >= 0; i--) begin
      sclk = 1'b1; m_dat = 1'b0; #H; got[i] = line; sclk = 1'b0; #H;
    end
    sclk = 1'b1; #(H/2); park_ok = sdata_oe && !line; #(H/2); sclk = 1'b0; #(H/2);
    park_ok = park_ok && !sdata_oe; #(H/2);
  endtask
  task automatic do_ext(input logic [3:0] sa, input logic [3:0] bc, input logic [7:0] a,
                        input logic [31:0] d, input int nb, input int badk);
    ssc(); frame({4'h0, sa, 4'b0000, bc}, 12, 1'b0); frame({8'h0, a}, 8, 1'b0);
    for (int k = 0; k < nb; k++) frame({8'h0, d[31-8*k -: 8]}, 8, k == badk);
    clk_bit(1'b0);
  endtask

  typedef struct packed {
    logic [1:0] kind;
    logic [3:0] sa;
    logic [4:0] addr;
    logic [7:0] data;
    logic [1:0] bad;
    logic       hit;
  } vec_t;

  localparam vec_t VT [12] = '{
    '{2'd0, 4'h7, 5'd5,  8'hA5, 2'd0, 1'b1},
    '{2'd0, 4'h3, 5'd5,  8'h11, 2'd0, 1'b0},
    '{2'd0, 4'h7, 5'd2,  8'h3C, 2'd1, 1'b0},
    '{2'd0, 4'h7, 5'd2,  8'h3C, 2'd2, 1'b0},
    '{2'd1, 4'h7, 5'd0,  8'h55, 2'd0, 1'b1},
    '{2'd1, 4'h7, 5'd0,  8'h2A, 2'd1, 1'b0},
    '{2'd0, 4'h0, 5'd28, 8'h38, 2'd0, 1'b1},
    '{2'd0, 4'h0, 5'd3,  8'h77, 2'd0, 1'b0},
    '{2'd2, 4'h7, 5'd4,  8'h00, 2'd0, 1'b1},
    '{2'd2, 4'h0, 5'd29, 8'h00, 2'd0, 1'b0},
    '{2'd2, 4'h5, 5'd9,  8'h00, 2'd0, 1'b0},
    '{2'd0, 4'h7, 5'd31, 8'hFF, 2'd0, 1'b1}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary(); $finish;
    end
  end

  initial begin
    logic [8:0] got;
    logic pk;
    int w0, r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 wr_en", {31'b0, wr_en}, 0);
    chk("R1 rd_en", {31'b0, rd_en}, 0);
    chk("R1 oe", {31'b0, sdata_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      vec_t v;
      v = VT[i];
      w0 = wcnt; r0 = rcnt; oe_seen = 1'b0;
      if (v.kind == 2'd2) begin
        do_read(v.sa, v.addr, got, pk);
        if (v.hit) begin
          chk("R6 read data+parity", {23'b0, got}, {23'b0, bank({3'b0, v.addr}), ~^bank({3'b0, v.addr})});
          chk("R6 rd_en count", rcnt - r0, 1);
          chk("R6 park low then release", {31'b0, pk}, 1);
        end else begin
          chk("R8 R9 ignored read no strobe", rcnt - r0, 0);
          chk("R8 R9 ignored read no drive", {31'b0, oe_seen}, 0);
        end
      end else begin
        if (v.kind == 2'd0) do_write(v.sa, v.addr, v.data, v.bad);
        else do_short(v.sa, v.data[6:0], v.bad);
        chk("R3 R4 R7 R8 R9 write count", wcnt - w0, {31'b0, v.hit});
        if (v.hit) begin
          chk("R3 R4 wr_addr", {24'b0, wa[w0]}, v.kind == 2'd1 ? 32'd0 : {27'b0, v.addr});
          chk("R3 R4 wr_data", {24'b0, wd[w0]}, v.kind == 2'd1 ? {25'b0, v.data[6:0]} : {24'b0, v.data});
        end
      end
    end

    w0 = wcnt;
    do_ext(4'h7, 4'd2, 8'h00, 32'h11223300, 3, -1);
    chk("R5 ext count", wcnt - w0, 3);
    chk("R5 ext addr0", {24'b0, wa[w0]}, 32'h00);
    chk("R5 ext addr2", {24'b0, wa[w0+2]}, 32'h02);
    chk("R5 ext data1", {24'b0, wd[w0+1]}, 32'h22);
    chk("R5 ext data2", {24'b0, wd[w0+2]}, 32'h33);

    w0 = wcnt;
    do_ext(4'h7, 4'd4, 8'h08, 32'hAABBCCDD, 4, -1);
    chk("R5 count above limit ignored", wcnt - w0, 0);

    w0 = wcnt;
    do_ext(4'h7, 4'd2, 8'h10, 32'h01020300, 3, 1);
    chk("R7 ext abort count", wcnt - w0, 1);
    chk("R7 ext first byte kept", {24'b0, wd[w0]}, 32'h01);

    w0 = wcnt;
    do_ext(4'h0, 4'd1, 8'd27, 32'h5152_0000, 2, -1);
    chk("R9 bcast ext count", wcnt - w0, 2);
    chk("R9 bcast ext addr", {24'b0, wa[w0+1]}, 32'd28);

    w0 = wcnt;
    ssc(); send({4'h0, 4'h7, 3'b010, 5'd9}, 6);
    do_write(4'h7, 5'd10, 8'h3C, 2'd0);
    chk("R2 resync count", wcnt - w0, 1);
    chk("R2 resync addr", {24'b0, wa[w0]}, 32'd10);
    chk("R2 resync data", {24'b0, wd[w0]}, 32'h3C);

    usid = 4'hB;
    w0 = wcnt;
    do_write(4'hB, 5'd7, 8'h81, 2'd0);
    chk("R8 new usid write", wcnt - w0, 1);
    chk("R8 new usid data", {24'b0, wd[w0]}, 32'h81);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule